// File: doc/BRIEF.md
# Integer Divide and Remainder Unit

This unit computes quotients and remainders of integer operands for a processor's execute stage. Every operation is signed or unsigned and yields either a quotient or a remainder. A word flag narrows the operation to the low half of the register width. Operands enter through a valid/ready handshake. The result leaves through a second valid/ready handshake and stays stable until the consumer takes it.

On the normal path a restoring divider finds one quotient bit per clock. It works on operand magnitudes, and the signs are applied in the last iteration. A zero divisor and a signed overflow never trap. Both are detected when the operation is accepted and give a fixed result on the next cycle. In word mode the operands are first widened from the low half. The result is then sign-extended from bit HALF-1, the top bit of the low half.

Top module: `int_divider`

## Requirements
- R1: With inOp = 1 (unsigned quotient) or inOp = 3 (unsigned remainder), and inWord = 0, the result is the unsigned quotient or remainder of inA by inB for any non-zero divisor.
- R2: With inOp = 0 (signed quotient) or inOp = 2 (signed remainder), operands are two's complement. The quotient truncates toward zero and the remainder takes the sign of the dividend.
- R3: A quotient operation (inOp = 0 or 1) whose effective divisor is zero returns all ones.
- R4: A remainder operation (inOp = 2 or 3) whose effective divisor is zero returns the effective dividend.
- R5: A signed operation whose effective dividend is the most negative value and whose effective divisor is -1 returns that dividend for inOp = 0 and zero for inOp = 2.
- R6: When inWord = 1, unsigned operations zero-extend the low HALF = XLEN/2 bits of each operand before dividing.
- R7: When inWord = 1, signed operations sign-extend the low HALF bits of each operand. Every word-mode result, unsigned ones included, is sign-extended from bit HALF-1.
- R8: outValid rises one cycle after acceptance for the R3/R4/R5 cases and XLEN+1 cycles after acceptance otherwise.
- R9: inReady is low from acceptance until the result is taken with outReady. While outValid is high and outReady is low, outResult holds its value.
- R10: A synchronous reset drops outValid and raises inReady on the next cycle, abandoning any operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Unit idle and accepting |
| inA | input | XLEN | Dividend |
| inB | input | XLEN | Divisor |
| inOp | input | 2 | 0 signed quotient, 1 unsigned quotient, 2 signed remainder, 3 unsigned remainder |
| inWord | input | 1 | Operate on low half, sign-extend result |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes result |
| outResult | output | XLEN | Quotient or remainder |

## Verification
The bench builds the unit with XLEN = 4. It sweeps every dividend and divisor pair through all four operations in both width modes. The expected values come from integer arithmetic in the bench. Zero divisors separate R3 from R4, and the pairs of the most negative value with -1 expose R5. Word mode with operands whose upper bits conflict with their low-half sign shows whether extension and re-extension (R6, R7) are done. The measured latency separates the bypass path from the iterative one. Stretched consumer back-pressure and a reset in mid-operation probe the handshake.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

  typedef enum logic [1:0] {
    OP_DIV  = 2'd0,
    OP_DIVU = 2'd1,
    OP_REM  = 2'd2,
    OP_REMU = 2'd3
  } divOp_e;

  typedef struct packed {
    logic issue;    // capture operands
    logic special;  // capture fixed result instead of iterating
    logic step;     // one restoring iteration
    logic finish;   // last iteration, write signed result
  } divCtrl_t;

endpackage

// File: rtl/div_datapath.sv
module div_datapath
  import intdiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic [XLEN-1:0] inA,
  input  logic [XLEN-1:0] inB,
  input  logic [1:0]      inOp,
  input  logic            inWord,
  input  divCtrl_t        ctrl,
  output logic            isSpecial,
  output logic [XLEN-1:0] result
);
  localparam int HALF = XLEN / 2;
  localparam int UPPER = XLEN - HALF;

  function automatic logic [XLEN-1:0] wordFix(input logic [XLEN-1:0] v, input logic w);
    return w ? {{UPPER{v[HALF-1]}}, v[HALF-1:0]} : v;
  endfunction

  logic            opUns, opRem;
  logic [XLEN-1:0] extA, extB, minVal, specVal, magA, magB;
  logic            divZero, sgnOvf, aNegIn, bNegIn;

  always_comb begin
    opUns = inOp[0];
    opRem = inOp[1];
    if (inWord) begin
      extA   = opUns ? {{UPPER{1'b0}}, inA[HALF-1:0]} : {{UPPER{inA[HALF-1]}}, inA[HALF-1:0]};
      extB   = opUns ? {{UPPER{1'b0}}, inB[HALF-1:0]} : {{UPPER{inB[HALF-1]}}, inB[HALF-1:0]};
      minVal = {{(UPPER+1){1'b1}}, {(HALF-1){1'b0}}};
    end else begin
      extA   = inA;
      extB   = inB;
      minVal = {1'b1, {(XLEN-1){1'b0}}};
    end
    divZero   = (extB == '0);
    sgnOvf    = !opUns && (extA == minVal) && (extB == '1);
    isSpecial = divZero || sgnOvf;
    if (divZero) specVal = opRem ? extA : '1;
    else         specVal = opRem ? '0 : extA;
    aNegIn = !opUns && extA[XLEN-1];
    bNegIn = !opUns && extB[XLEN-1];
    magA   = aNegIn ? (~extA + 1'b1) : extA;
    magB   = bNegIn ? (~extB + 1'b1) : extB;
  end

  logic [XLEN-1:0] remR, quoR, dsrR;
  logic            qNegR, rNegR, remSelR, wordR;

  logic [XLEN:0]   shifted, diff;
  logic            fits;
  logic [XLEN-1:0] remNext, quoNext, qSigned, rSigned;

  always_comb begin
    shifted = {remR, quoR[XLEN-1]};
    diff    = shifted - {1'b0, dsrR};
    fits    = !diff[XLEN];
    remNext = fits ? diff[XLEN-1:0] : shifted[XLEN-1:0];
    quoNext = {quoR[XLEN-2:0], fits};
    qSigned = qNegR ? (~quoNext + 1'b1) : quoNext;
    rSigned = rNegR ? (~remNext + 1'b1) : remNext;
  end

  always_ff @(posedge clk) begin
    if (ctrl.issue) begin
      remR    <= '0;
      quoR    <= magA;
      dsrR    <= magB;
      qNegR   <= aNegIn ^ bNegIn;
      rNegR   <= aNegIn;
      remSelR <= opRem;
      wordR   <= inWord;
    end else if (ctrl.step) begin
      remR <= remNext;
      quoR <= quoNext;
    end
    if (ctrl.special)     result <= wordFix(specVal, inWord);
    else if (ctrl.finish) result <= wordFix(remSelR ? rSigned : qSigned, wordR);
  end
endmodule

// File: rtl/div_control.sv
module div_control
  import intdiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  input  logic     outReady,
  input  logic     isSpecial,
  output logic     inReady,
  output logic     outValid,
  output divCtrl_t ctrl
);
  localparam int CW = $clog2(XLEN);
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_e;
  state_e        state;
  logic [CW-1:0] cnt;
  logic          accept;

  always_comb begin
    accept       = (state == S_IDLE) && inValid;
    ctrl.issue   = accept;
    ctrl.special = accept && isSpecial;
    ctrl.step    = (state == S_BUSY);
    ctrl.finish  = (state == S_BUSY) && (cnt == LAST);
    inReady      = (state == S_IDLE);
    outValid     = (state == S_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (inValid) state <= isSpecial ? S_DONE : S_BUSY;
        end
        S_BUSY: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_DONE;
        end
        S_DONE:  if (outReady) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/int_divider.sv
module int_divider
  import intdiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  output logic            inReady,
  input  logic [XLEN-1:0] inA,
  input  logic [XLEN-1:0] inB,
  input  logic [1:0]      inOp,
  input  logic            inWord,
  output logic            outValid,
  input  logic            outReady,
  output logic [XLEN-1:0] outResult
);
  divCtrl_t ctrl;
  logic     isSpecial;

  div_control #(.XLEN(XLEN)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .isSpecial(isSpecial), .inReady(inReady), .outValid(outValid), .ctrl(ctrl)
  );

  div_datapath #(.XLEN(XLEN)) u_dp (
    .clk(clk), .inA(inA), .inB(inB), .inOp(inOp), .inWord(inWord),
    .ctrl(ctrl), .isSpecial(isSpecial), .result(outResult)
  );
endmodule

// File: rtl/int_divider_checker.sv
module int_divider_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            inValid,
  input logic            inReady,
  input logic [XLEN-1:0] inB,
  input logic [1:0]      inOp,
  input logic            inWord,
  input logic            outValid,
  input logic            outReady,
  input logic [XLEN-1:0] outResult
);
  a_r10_reset_idle: assert property (@(posedge clk) rst |=> (!outValid && inReady));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady);

  a_r9_ready_low_with_result: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);

  a_r9_hold_result: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outResult)));

  a_r3_zero_quotient: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && !inWord && inB == '0 && !inOp[1]) |=> (outValid && outResult == '1));
endmodule

bind int_divider int_divider_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inB(inB),
  .inOp(inOp), .inWord(inWord), .outValid(outValid), .outReady(outReady),
  .outResult(outResult)
);

// File: tb/int_divider_tb.sv
module int_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 4;
  localparam int HALF = XLEN / 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            inValid = 1'b0;
  logic            inReady;
  logic [XLEN-1:0] inA = '0;
  logic [XLEN-1:0] inB = '0;
  logic [1:0]      inOp = '0;
  logic            inWord = 1'b0;
  logic            outValid;
  logic            outReady = 1'b0;
  logic [XLEN-1:0] outResult;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_divider #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inA(inA),
    .inB(inB), .inOp(inOp), .inWord(inWord), .outValid(outValid),
    .outReady(outReady), .outResult(outResult)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int widen(input logic [XLEN-1:0] v, input logic uns, input logic word);
    int w;
    if (word) begin
      w = int'(v[HALF-1:0]);
      if (!uns && v[HALF-1]) w = w - (1 << HALF);
    end else begin
      w = int'(v);
      if (!uns && v[XLEN-1]) w = w - (1 << XLEN);
    end
    return w;
  endfunction

  function automatic int model(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                               input logic [1:0] op, input logic word);
    int sa, sb, r;
    logic [XLEN-1:0] v;
    sa = widen(a, op[0], word);
    sb = widen(b, op[0], word);
    if (sb == 0) r = op[1] ? sa : -1;
    else         r = op[1] ? (sa % sb) : (sa / sb);
    v = r[XLEN-1:0];
    if (word) v = {{(XLEN-HALF){v[HALF-1]}}, v[HALF-1:0]};
    return int'(v);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat, exp, sa, sb, expLat;
    string tag;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset inReady", int'(inReady), 1);
    check("R10 reset outValid", int'(outValid), 0);
    rst = 1'b0;

    for (int w = 0; w < 2; w++) begin
      for (int op = 0; op < 4; op++) begin
        for (int a = 0; a < (1 << XLEN); a++) begin
          for (int b = 0; b < (1 << XLEN); b++) begin
            @(negedge clk);
            check("R9 ready before issue", int'(inReady), 1);
            inA = XLEN'(a); inB = XLEN'(b); inOp = 2'(op); inWord = w[0];
            inValid = 1'b1;
            @(negedge clk);
            inValid = 1'b0;
            check("R9 ready low after issue", int'(inReady), 0);
            lat = 1;
            while (!outValid && lat < 40) begin
              @(negedge clk);
              lat++;
            end
            sa = widen(XLEN'(a), op[0], w[0]);
            sb = widen(XLEN'(b), op[0], w[0]);
            expLat = (sb == 0 || (op[0] == 0 && sa == (w ? -(1 << (HALF-1)) : -(1 << (XLEN-1))) && sb == -1)) ? 1 : XLEN + 1;
            check("R8 latency", lat, expLat);
            exp = model(XLEN'(a), XLEN'(b), 2'(op), w[0]);
            if (sb == 0) tag = op[1] ? "R4" : "R3";
            else if (expLat == 1) tag = "R5";
            else if (w == 1) tag = op[0] ? "R6" : "R7";
            else tag = op[0] ? "R1" : "R2";
            check(tag, int'(outResult), exp);
            if (((a + b) % 5) == 0) begin
              repeat (2) @(negedge clk);
              check("R9 held valid", int'(outValid), 1);
              check("R9 held value", int'(outResult), exp);
            end
            outReady = 1'b1;
            @(negedge clk);
            outReady = 1'b0;
            check("R9 released", int'(outValid), 0);
          end
        end
      end
    end

    // R10: reset while an iteration is running
    @(negedge clk);
    inA = 4'd7; inB = 4'd2; inOp = 2'd1; inWord = 1'b0; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 abort outValid", int'(outValid), 0);
    check("R10 abort inReady", int'(inReady), 1);
    repeat (XLEN + 2) @(negedge clk);
    check("R10 stays idle", int'(outValid), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule